// File: doc/BRIEF.md
# Configurable Watchdog Timer

This block is a watchdog counter that raises a reset request when software fails to refresh it in time. A small mode byte, written through a write-only port, chooses one of four timeout lengths, picks whether the counter advances on every system clock (crystal source) or only on cycles flagged by a slow-oscillator clock-enable input (RC source), and decides separately whether counting continues while the core is halted and while it is stopped.

Each refresh strobe and each mode write clears the count to zero. When the selected number of count ticks has passed without a refresh, the block emits a single-cycle reset request and starts counting again from zero. The slow oscillator itself is not modelled; a one-cycle-wide enable pulse on `rc_tick` stands for each of its edges.

Top module: `wdog_timer`

## Requirements
- R1: After reset `wdt_rst` is low and the mode is tap 1, RC source, counting on during halt and during stop. Mode byte layout: bits 1:0 tap code, bit 2 halt counting enable, bit 3 stop counting enable, bit 4 source select (0 = RC, 1 = crystal); the reset value is therefore 8'h0D.
- R2: With the crystal source and no halt or stop, `wdt_rst` rises after 128, 256, 512 or 2048 clock edges for tap codes 0, 1, 2 and 3, counted from the clearing edge.
- R3: With the RC source the counter advances only on clock edges where `rc_tick` is high, so the timeout is the tap length times the spacing of `rc_tick` pulses; with the crystal source `rc_tick` has no effect.
- R4: The reset request is exactly one cycle wide, and counting restarts from zero on the same edge that raises it.
- R5: A clock edge with `kick` high clears the count to zero without raising a request; the full tap length then elapses before the next request.
- R6: A clock edge with `cfg_we` high loads the mode byte and clears the count, so a new tap is timed from zero.
- R7: While `halt` is high and halt counting is disabled, the count holds and no request is raised; with halt counting enabled, counting continues at the normal rate.
- R8: While `stop` is high and stop counting is disabled, the count holds and no request is raised.
- R9: Mode byte bits 7:5 are reserved; writing them with any value has no effect on the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_tick | input | 1 | Clock enable standing for one slow-oscillator edge |
| cfg_we | input | 1 | Mode byte write strobe |
| cfg_wdata | input | 8 | Mode byte write data |
| kick | input | 1 | Refresh strobe, clears the count |
| halt | input | 1 | Core is in halt |
| stop | input | 1 | Core is in stop |
| wdt_rst | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong count, tap decode or gating decision shows at the port only as a reset request that arrives early, late or never, so every scenario measures the exact edge count from a clearing event to the request and compares it against the tap length times the tick spacing. An error in the limit compare or the restart appears within one timeout period, at most a few thousand cycles, and a stuck or doubled pulse appears on the very next cycle after the request. Held counts during halt or stop are exposed by the remaining distance to expiry after the hold ends.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef struct packed {
        logic [1:0] tap;
        logic       halt_en;
        logic       stop_en;
        logic       xtal_sel;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_RESET = '{tap: 2'b01, halt_en: 1'b1, stop_en: 1'b1, xtal_sel: 1'b0};

    localparam int MODE_W = 8;

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output wdt_cfg_t          cfg
);

    wdt_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.tap      = wdata[1:0];
            cfg_d.halt_en  = wdata[2];
            cfg_d.stop_en  = wdata[3];
            cfg_d.xtal_sel = wdata[4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q)) else $error("cfg changed without write"); // R6

endmodule

// File: rtl/wdt_tick_gate.sv
module wdt_tick_gate
    import wdt_pkg::*;
(
    input  wdt_cfg_t cfg,
    input  logic     rc_tick,
    input  logic     halt,
    input  logic     stop,
    output logic     adv
);

    logic halt_block;
    logic stop_block;
    logic src_tick;

    always_comb begin
        halt_block = halt && !cfg.halt_en;
        stop_block = stop && !cfg.stop_en;
        src_tick   = cfg.xtal_sel ? 1'b1 : rc_tick;
        adv        = src_tick && !halt_block && !stop_block;
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int TAP0  = 128,
    parameter int TAP1  = 256,
    parameter int TAP2  = 512,
    parameter int TAP3  = 2048,
    parameter int CNT_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       clr,
    input  logic [1:0] tap,
    output logic       expire
);

    localparam int LIMS [4] = '{TAP0, TAP1, TAP2, TAP3};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = CNT_W'(LIMS[tap] - 1);
        st_d     = st_q;
        st_d.pulse = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (st_q.cnt >= last) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse) else $error("request longer than one cycle"); // R4
    AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.cnt == '0) else $error("count not restarted"); // R4
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && !st_q.pulse)) else $error("clear failed"); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> ($stable(st_q.cnt) && !st_q.pulse)) else $error("count moved while held"); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last) else $error("count beyond tap limit"); // R2

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int TAP0 = 128,
    parameter int TAP1 = 256,
    parameter int TAP2 = 512,
    parameter int TAP3 = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rc_tick,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    input  logic              kick,
    input  logic              halt,
    input  logic              stop,
    output logic              wdt_rst
);

    localparam int MAX01 = (TAP0 > TAP1) ? TAP0 : TAP1;
    localparam int MAX23 = (TAP2 > TAP3) ? TAP2 : TAP3;
    localparam int MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAXT);

    wdt_cfg_t cfg;
    logic     adv;
    logic     clr;

    assign clr = kick || cfg_we;

    wdt_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    wdt_tick_gate i_gate (
        .cfg     (cfg),
        .rc_tick (rc_tick),
        .halt    (halt),
        .stop    (stop),
        .adv     (adv)
    );

    wdt_counter #(
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3),
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .clr    (clr),
        .tap    (cfg.tap),
        .expire (wdt_rst)
    );

    AST_RC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.xtal_sel && !rc_tick) |-> !adv) else $error("advance without rc tick"); // R3
    AST_STOP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !cfg.stop_en && !clr) |=> !wdt_rst) else $error("expiry while stop held"); // R8
    AST_HALT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !cfg.halt_en && !clr) |=> !wdt_rst) else $error("expiry while halt held"); // R7

endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rc_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       kick = 1'b0;
    logic       halt = 1'b0;
    logic       stop = 1'b0;
    logic       wdt_rst;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int k_div = 0;

    always #5 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_tick   (rc_tick),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .kick      (kick),
        .halt      (halt),
        .stop      (stop),
        .wdt_rst   (wdt_rst)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
        summary();
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // edges until wdt_rst is seen; rc_tick every k_div-th edge (0 = never)
    task automatic wait_pulse(output int n);
        n = 0;
        while (n < 20000) begin
            rc_tick = (k_div == 0) ? 1'b0 : (((n + 1) % k_div) == 0);
            step();
            n++;
            if (wdt_rst) break;
        end
        rc_tick = 1'b0;
    endtask

    task automatic write_mode(logic [7:0] v);
        cfg_wdata = v;
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    // run edges that must not produce a request; returns count of requests seen
    task automatic quiet(int edges, output int seen);
        seen = 0;
        for (int i = 0; i < edges; i++) begin
            rc_tick = 1'b1;
            step();
            if (wdt_rst) seen++;
        end
        rc_tick = 1'b0;
    endtask

    function automatic int tap_len(int t);
        return (t == 3) ? 2048 : (128 << t);
    endfunction

    initial begin
        int n;
        int seen;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state and defaults (tap 1, RC source)
        check("R1 reset output", int'(wdt_rst), 0);
        k_div = 1;
        wait_pulse(n);
        check("R1 default tap1 rc", n, 256);

        // R2/R3: sweep taps and sources
        for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < 4; s++) begin
                logic [7:0] m;
                m = 8'(t) | 8'h0C | ((s == 0) ? 8'h10 : 8'h00);
                k_div = s;
                write_mode(m);
                wait_pulse(n);
                if (s == 0) check("R2 crystal tap length", n, tap_len(t));
                else        check("R3 rc tap length", n, tap_len(t) * s);
                // R4: one-cycle wide, restart from zero
                rc_tick = (s <= 1) ? 1'b1 : 1'b0;
                if (s == 0) rc_tick = 1'b0;
                step();
                check("R4 pulse width", int'(wdt_rst), 0);
            end
        end

        // R4: restart period after expiry (crystal tap0)
        k_div = 0;
        write_mode(8'h1C);
        wait_pulse(n);
        step();
        check("R4 first cycle after request", int'(wdt_rst), 0);
        wait_pulse(n);
        check("R4 restart period", n, 127);

        // R5: kick clears
        write_mode(8'h1C);
        quiet(100, seen);
        kick = 1'b1;
        step();
        kick = 1'b0;
        check("R5 no request from kick", int'(wdt_rst) + seen, 0);
        wait_pulse(n);
        check("R5 full period after kick", n, 128);

        // R6: write mid-count restarts with new tap
        write_mode(8'h13);
        quiet(1000, seen);
        write_mode(8'h10);
        wait_pulse(n);
        check("R6 new tap from zero", n + seen, 128);

        // R7: halt with counting disabled holds the count
        write_mode(8'h18);
        quiet(50, seen);
        halt = 1'b1;
        begin
            int s2;
            quiet(500, s2);
            seen += s2;
        end
        halt = 1'b0;
        check("R7 no request in halt", seen, 0);
        wait_pulse(n);
        check("R7 remaining after halt", n, 78);

        // R7: halt with counting enabled keeps counting
        write_mode(8'h1C);
        halt = 1'b1;
        wait_pulse(n);
        halt = 1'b0;
        check("R7 counting in halt", n, 128);

        // R8: stop with counting disabled holds the count
        write_mode(8'h14);
        quiet(60, seen);
        stop = 1'b1;
        begin
            int s2;
            quiet(700, s2);
            seen += s2;
        end
        stop = 1'b0;
        check("R8 no request in stop", seen, 0);
        wait_pulse(n);
        check("R8 remaining after stop", n, 68);

        // R9: reserved bits ignored
        write_mode(8'hF1);
        wait_pulse(n);
        check("R9 reserved bits tap1", n, 256);
        k_div = 2;
        write_mode(8'hAC);
        wait_pulse(n);
        check("R9 reserved bits rc tap0", n, 256);

        summary();
    end

endmodule